// File: doc/BRIEF.md
# Adaptive Ring Steering Threshold Controller

This block chooses, packet by packet, whether an outgoing message is placed on a fast but narrow broadcast ring or left on the high-throughput switched mesh. An upstream stage supplies a signed benefit score for each packet. The block takes a fixed penalty off that score when the packet is marked as unlikely to be on a critical path, such as a write-back. It then compares the result with a signed threshold held inside the block. Only packets that beat the threshold are steered to the ring.

The threshold adapts to the ring's load. A pulse input reports every packet this node sees pass on the ring. The block counts these pulses over a measurement window of configurable length. At the end of each window it compares the busy time implied by the count with a target utilization. Busy time is the count times the configured per-packet ring occupancy. The threshold then moves one step up when the ring is too busy, one step down when it is underused, and stays where it is on an exact match. A window of 512 cycles and a target of 75 percent are the usual settings. The comparison is done by cross-multiplying, so no divider is needed.

Top module: `steer_thr_ctrl`

## Requirements
- R1: `steer_ring` is 1 exactly when `pkt_valid` is 1 and the effective score is strictly greater than the current threshold `thr_out`. An effective score equal to the threshold gives 0, and `steer_ring` is 0 whenever `pkt_valid` is 0. The decision is combinational in the same cycle.
- R2: The effective score is `pkt_score` (two's complement) when `pkt_noncrit` is 0. It is `pkt_score` minus NONCRIT_PENALTY (default 8) when `pkt_noncrit` is 1.
- R3: A per-window ring counter increases by one in each cycle in which `ring_seen` is 1. It saturates at its maximum value.
- R4: A window ends in the cycle in which the number of cycles elapsed in it reaches `cfg_window`. The first window starts in the first cycle after reset is released. At a window end, the count used for the decision includes a `ring_seen` pulse in that same cycle, and the counter restarts from zero.
- R5: At a window end, let n be the count. If `cfg_ring_lat` × n × 100 is greater than `cfg_target_pct` × `cfg_window`, the threshold rises by 1. If it is smaller, the threshold falls by 1. If the two are equal, the threshold is unchanged. The new value appears on `thr_out` after that clock edge.
- R6: The threshold changes only at window ends. It is an 8-bit two's-complement value that stops at +127 and at −128 instead of wrapping.
- R7: While `rst_n` is 0 at a clock edge, the threshold and all counters return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_valid | input | 1 | A packet awaits a steering decision this cycle |
| pkt_score | input | 10 | Signed benefit score of the packet |
| pkt_noncrit | input | 1 | Packet is unlikely to be critical; apply the penalty |
| steer_ring | output | 1 | 1: send on the ring, 0: send on the mesh |
| ring_seen | input | 1 | One-cycle pulse per packet observed on the ring |
| cfg_ring_lat | input | 4 | Ring cycles occupied per packet |
| cfg_target_pct | input | 7 | Target utilization in percent |
| cfg_window | input | 10 | Measurement window length in cycles |
| thr_out | output | 8 | Current signed threshold |

## Verification
The bench aims scores at the threshold and one above it. A design using greater-or-equal would steer the equal case to the ring. It also drives a load pattern that makes busy time exactly equal to the target. A design that treated equality as "above" or "below" would drift the threshold away from zero. In the equality pattern, the last pulse of each window lands on the window-end cycle. A design that dropped that pulse during read-and-clear would see the ring as underused and walk the threshold downward. A long saturated phase followed by an idle phase pushes the threshold against both limits, where a wrapping register would jump to the opposite sign.

// File: rtl/steer_pkg.sv
// Package: shared types of the ring steering threshold controller.
// Assumes nothing beyond a standard SystemVerilog compiler.
package steer_pkg;

    // Direction in which the threshold moves at a window end
    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_e;

    // Larger of two widths, used to size comparison operands
    function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/steer_win_timer.sv
// Module: measurement window timer.
// Counts cycles and raises win_end in the last cycle of each window.
// Assumes cfg_window may change at any time; a window closes as soon as its
// elapsed count reaches the current setting (a setting of 0 closes every cycle).
module steer_win_timer #(
    parameter int unsigned WIN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] cfg_window,
    output logic             win_end
);
    logic [WIN_W-1:0] pos_q;
    logic [WIN_W:0]   elapsed;

    // Number of cycles in the window including the current one
    always_comb begin
        elapsed = {1'b0, pos_q} + (WIN_W+1)'(1);
        win_end = (elapsed >= {1'b0, cfg_window});
    end

    // Advance position, restart at window end
    always_ff @(posedge clk) begin
        if (!rst_n)       pos_q <= '0;
        else if (win_end) pos_q <= '0;
        else              pos_q <= pos_q + WIN_W'(1);
    end
endmodule

// File: rtl/steer_ring_meter.sv
// Module: ring traffic meter.
// Counts ring_seen pulses per window with saturation. n_win gives the count
// including the current cycle's pulse, so a read at the window end sees it.
// Assumes win_end comes from the window timer of the same clock domain.
module steer_ring_meter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_seen,
    input  logic             win_end,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] n_win
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Saturating count including this cycle's pulse
    always_comb begin
        if (ring_seen && (cnt_q != CNT_MAX)) n_win = cnt_q + CNT_W'(1);
        else                                 n_win = cnt_q;
    end

    // Keep the running count, clear on read at window end
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (win_end) cnt_q <= '0;
        else              cnt_q <= n_win;
    end
endmodule

// File: rtl/steer_util_cmp.sv
// Module: utilization comparator.
// Decides the threshold move by comparing lat*n*100 against pct*window,
// which avoids a divider. Purely combinational.
// Assumes all operands are unsigned.
module steer_util_cmp #(
    parameter int unsigned LAT_W = 4,
    parameter int unsigned CNT_W = 10,
    parameter int unsigned PCT_W = 7,
    parameter int unsigned WIN_W = 10
) (
    input  logic [LAT_W-1:0]  cfg_ring_lat,
    input  logic [CNT_W-1:0]  n_win,
    input  logic [PCT_W-1:0]  cfg_target_pct,
    input  logic [WIN_W-1:0]  cfg_window,
    output steer_pkg::adj_e   adj
);
    localparam int unsigned LHS_W = LAT_W + CNT_W + 7;
    localparam int unsigned RHS_W = PCT_W + WIN_W;
    localparam int unsigned CMP_W = steer_pkg::wmax(LHS_W, RHS_W) + 1;
    localparam logic [CMP_W-1:0] HUNDRED = CMP_W'(100);

    logic [CMP_W-1:0] busy_scaled;
    logic [CMP_W-1:0] goal_scaled;

    // Cross-multiplied comparison of measured and target utilization
    always_comb begin
        busy_scaled = CMP_W'(cfg_ring_lat) * CMP_W'(n_win) * HUNDRED;
        goal_scaled = CMP_W'(cfg_target_pct) * CMP_W'(cfg_window);
        if (busy_scaled > goal_scaled)      adj = steer_pkg::ADJ_UP;
        else if (busy_scaled < goal_scaled) adj = steer_pkg::ADJ_DOWN;
        else                                adj = steer_pkg::ADJ_HOLD;
    end
endmodule

// File: rtl/steer_thr_reg.sv
// Module: saturating threshold register.
// Steps the signed threshold by one at window ends, clamped at both limits.
// Assumes adj is only meaningful while win_end is high.
module steer_thr_reg #(
    parameter int unsigned THR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_end,
    input  steer_pkg::adj_e         adj,
    output logic signed [THR_W-1:0] thr_q
);
    localparam logic signed [THR_W-1:0] THR_MAX = {1'b0, {(THR_W-1){1'b1}}};
    localparam logic signed [THR_W-1:0] THR_MIN = {1'b1, {(THR_W-1){1'b0}}};

    logic signed [THR_W-1:0] thr_d;

    // Next threshold with saturation at both ends
    always_comb begin
        thr_d = thr_q;
        if (win_end) begin
            if (adj == steer_pkg::ADJ_UP && thr_q != THR_MAX)
                thr_d = thr_q + THR_W'(1);
            else if (adj == steer_pkg::ADJ_DOWN && thr_q != THR_MIN)
                thr_d = thr_q - THR_W'(1);
        end
    end

    // Threshold state
    always_ff @(posedge clk) begin
        if (!rst_n) thr_q <= '0;
        else        thr_q <= thr_d;
    end
endmodule

// File: rtl/steer_decide.sv
// Module: per-packet steering decision.
// Applies the non-critical penalty and compares strictly against the threshold.
// Assumes score and threshold are two's complement; widens both to avoid overflow.
module steer_decide #(
    parameter int unsigned SCORE_W         = 10,
    parameter int unsigned THR_W           = 8,
    parameter int unsigned NONCRIT_PENALTY = 8
) (
    input  logic                      pkt_valid,
    input  logic signed [SCORE_W-1:0] pkt_score,
    input  logic                      pkt_noncrit,
    input  logic signed [THR_W-1:0]   thr,
    output logic                      steer_ring
);
    localparam int unsigned EXT_W = steer_pkg::wmax(SCORE_W, THR_W) + 2;
    localparam logic signed [EXT_W-1:0] PENALTY = EXT_W'(NONCRIT_PENALTY);

    logic signed [EXT_W-1:0] score_ext;
    logic signed [EXT_W-1:0] thr_ext;
    logic signed [EXT_W-1:0] eff_score;

    // Penalised score against threshold, strict comparison
    always_comb begin
        score_ext  = EXT_W'(pkt_score);
        thr_ext    = EXT_W'(thr);
        eff_score  = pkt_noncrit ? (score_ext - PENALTY) : score_ext;
        steer_ring = pkt_valid && (eff_score > thr_ext);
    end
endmodule

// File: rtl/steer_thr_ctrl.sv
// Module: adaptive ring steering threshold controller (top).
// Steers packets to the ring when their penalised score beats a threshold that
// is adjusted once per window from measured ring utilization.
// Assumes single clock, synchronous active-low reset, configuration quasi-static.
module steer_thr_ctrl #(
    parameter int unsigned SCORE_W         = 10,
    parameter int unsigned THR_W           = 8,
    parameter int unsigned LAT_W           = 4,
    parameter int unsigned PCT_W           = 7,
    parameter int unsigned WIN_W           = 10,
    parameter int unsigned NONCRIT_PENALTY = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pkt_valid,
    input  logic signed [SCORE_W-1:0] pkt_score,
    input  logic                      pkt_noncrit,
    output logic                      steer_ring,
    input  logic                      ring_seen,
    input  logic [LAT_W-1:0]          cfg_ring_lat,
    input  logic [PCT_W-1:0]          cfg_target_pct,
    input  logic [WIN_W-1:0]          cfg_window,
    output logic signed [THR_W-1:0]   thr_out
);
    localparam int unsigned CNT_W = WIN_W;

    logic             win_end;
    logic [CNT_W-1:0] ring_cnt;
    logic [CNT_W-1:0] n_win;
    steer_pkg::adj_e  adj;

    steer_win_timer #(.WIN_W(WIN_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window), .win_end(win_end)
    );

    steer_ring_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .ring_seen(ring_seen), .win_end(win_end),
        .cnt_q(ring_cnt), .n_win(n_win)
    );

    steer_util_cmp #(.LAT_W(LAT_W), .CNT_W(CNT_W), .PCT_W(PCT_W), .WIN_W(WIN_W)) u_cmp (
        .cfg_ring_lat(cfg_ring_lat), .n_win(n_win), .cfg_target_pct(cfg_target_pct),
        .cfg_window(cfg_window), .adj(adj)
    );

    steer_thr_reg #(.THR_W(THR_W)) u_thr (
        .clk(clk), .rst_n(rst_n), .win_end(win_end), .adj(adj), .thr_q(thr_out)
    );

    steer_decide #(.SCORE_W(SCORE_W), .THR_W(THR_W), .NONCRIT_PENALTY(NONCRIT_PENALTY)) u_dec (
        .pkt_valid(pkt_valid), .pkt_score(pkt_score), .pkt_noncrit(pkt_noncrit),
        .thr(thr_out), .steer_ring(steer_ring)
    );
endmodule

// File: rtl/steer_thr_chk.sv
// Module: assertion checker for steer_thr_ctrl, attached by bind.
// Assumes the same clock and synchronous active-low reset as the controller.
module steer_thr_chk #(
    parameter int unsigned THR_W = 8,
    parameter int unsigned CNT_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pkt_valid,
    input logic                    steer_ring,
    input logic                    ring_seen,
    input logic                    win_end,
    input logic [CNT_W-1:0]        ring_cnt,
    input logic signed [THR_W-1:0] thr_out
);
    // R1: no ring steering without a packet
    p_steer_needs_pkt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        steer_ring |-> pkt_valid);

    // R3: a pulse inside a window raises the count by one
    p_cnt_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_end && ring_seen && ring_cnt != '1) |=> (ring_cnt == $past(ring_cnt) + CNT_W'(1)));

    // R4: counter restarts after a window end
    p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (ring_cnt == '0));

    // R6: threshold holds between window ends
    p_thr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(thr_out));

    // R5: threshold moves by at most one per window end
    p_thr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> ((thr_out == $past(thr_out)) ||
                     (thr_out == $past(thr_out) + THR_W'(1)) ||
                     (thr_out == $past(thr_out) - THR_W'(1))));
endmodule

bind steer_thr_ctrl steer_thr_chk #(.THR_W(THR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .steer_ring(steer_ring),
    .ring_seen(ring_seen), .win_end(win_end), .ring_cnt(ring_cnt), .thr_out(thr_out)
);

// File: tb/steer_thr_ctrl_bench.sv
module steer_thr_ctrl_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pkt_valid = 1'b0;
    logic signed [9:0] pkt_score = '0;
    logic              pkt_noncrit = 1'b0;
    logic              steer_ring;
    logic              ring_seen = 1'b0;
    logic [3:0]        cfg_ring_lat = 4'd1;
    logic [6:0]        cfg_target_pct = 7'd75;
    logic [9:0]        cfg_window = 10'd512;
    logic signed [7:0] thr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    int m_thr, m_pos, m_cnt, m_win_idx, win_p;

    always #10 clk = ~clk;

    steer_thr_ctrl u_steer_thr_ctrl (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_score(pkt_score),
        .pkt_noncrit(pkt_noncrit), .steer_ring(steer_ring), .ring_seen(ring_seen),
        .cfg_ring_lat(cfg_ring_lat), .cfg_target_pct(cfg_target_pct),
        .cfg_window(cfg_window), .thr_out(thr_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_steer(input bit v, input int sc, input bit nc, input int thr);
        int eff;
        eff = nc ? sc - 8 : sc;
        return v && (eff > thr);
    endfunction

    function automatic int next_thr(input int thr, input int lat, input int n,
                                    input int pct, input int win);
        int lhs, rhs;
        lhs = lat * n * 100;
        rhs = pct * win;
        if (lhs > rhs && thr < 127)  return thr + 1;
        if (lhs < rhs && thr > -128) return thr - 1;
        return thr;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        pkt_valid = 1'b0;
        ring_seen = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(thr_out == 0, "R7 thr after reset", int'(thr_out), 0);
        chk(steer_ring == 1'b0, "R7 steer idle after reset", int'(steer_ring), 0);
        rst_n = 1'b1;
        m_thr = 0; m_pos = 0; m_cnt = 0; m_win_idx = 0;
    endtask

    // mode 0 random, 1 saturate up then down, 2 exact-target with end-cycle pulse
    task automatic run_phase(input int lat, input int pct, input int win,
                             input int cycles, input int mode);
        cfg_ring_lat = 4'(lat);
        cfg_target_pct = 7'(pct);
        cfg_window = 10'(win);
        do_reset();
        win_p = $urandom_range(0, 100);
        for (int c = 0; c < cycles; c++) begin
            int sc;
            bit nc, v, rs;
            v  = ($urandom_range(0, 3) != 0);
            nc = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0)
                sc = m_thr + (nc ? 8 : 0) + $urandom_range(0, 1);
            else
                sc = $urandom_range(0, 1023) - 512;
            case (mode)
                1:       rs = (m_win_idx < 140);
                2:       rs = (m_pos >= win - 2);
                default: rs = ($urandom_range(0, 99) < win_p);
            endcase
            pkt_valid = v; pkt_score = 10'(sc); pkt_noncrit = nc; ring_seen = rs;
            #1;
            // R1 strict compare, R2 penalty
            chk(steer_ring == exp_steer(v, sc, nc, m_thr), nc ? "R2 penalised steer" : "R1 steer",
                int'(steer_ring), int'(exp_steer(v, sc, nc, m_thr)));
            // R5/R6 threshold tracks model
            chk(int'(thr_out) == m_thr, mode == 2 ? "R4 end-cycle pulse hold" :
                (mode == 1 ? "R6 saturation" : "R5 threshold"), int'(thr_out), m_thr);
            // model the coming clock edge
            if (rs) m_cnt++;            // R3
            if (m_pos + 1 >= win) begin // R4
                m_thr = next_thr(m_thr, lat, m_cnt, pct, win);
                m_cnt = 0; m_pos = 0; m_win_idx++;
                win_p = $urandom_range(0, 100);
            end else begin
                m_pos++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        run_phase(3, 75, 64, 4000, 0);
        run_phase(1, 75, 512, 6000, 0);
        run_phase(8, 40, 32, 3000, 0);
        run_phase(15, 100, 4, 1700, 1);
        chk(m_thr == -128, "R6 reached lower limit", m_thr, -128);
        run_phase(1, 50, 4, 400, 2);
        run_phase(2, 50, 4, 400, 2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule